// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block gives a group of processor cores a small set of memory-mapped mailboxes for signalling each other. It holds four 32-bit message slots and one enable register. A core posts a message by writing a slot. If that slot is enabled and allowed to interrupt, the write sets a pending flag, and the flag drives the slot's interrupt output. The receiving core fetches the message by reading the slot, and that read also acknowledges the interrupt.

The slots sit on a simple synchronous register bus. Slot i is at byte offset i*0x10 and the enable register is at offset 0x100. A static receive-mask parameter, which defaults to all slots, fixes at build time which slots can raise an interrupt at all. Writes take effect at the clock edge. Read data is combinational from the current state while the read strobe is high and is zero otherwise.

Top module: `ipc_msg_bank`

## Requirements
- R1: After reset every slot value, the enable register and every interrupt output are zero.
- R2: Slot i decodes at byte offset i*0x10 (0x000, 0x010, 0x020, 0x030) and the enable register at 0x100. A read of any other offset, and `rdata` whenever `rd_en` is low, gives zero.
- R3: A write to slot i while enable bit i and receive-mask bit i are both set stores `wdata` and raises `irq[i]` from the next cycle.
- R4: A read of slot i returns its stored value and drops `irq[i]` from the next cycle. The stored value is kept.
- R5: A write to a slot whose enable bit is clear stores the value and leaves its interrupt low.
- R6: A write to a slot whose receive-mask bit is 0 stores the value and never raises its interrupt, whatever the enable bit.
- R7: Bit i of the enable register controls slot i. Enable-register bits 4 and above are ignored and read back as zero.
- R8: Clearing enable bit i drops a pending `irq[i]` on the next cycle. Setting the bit again does not raise it again before a new write.
- R9: When a write and a read hit the same slot in the same cycle, the write wins. The new value is stored, the interrupt ends up set if the slot is armed, and `rdata` shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 9 | Byte offset from the block base |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 4 | Per-slot interrupt, high while a message is pending |

## Verification
The bench sweeps every slot against all sixteen enable patterns, using a receive mask of 0b1011 so that slot 2 can never interrupt. A design that armed on the enable bit alone, or that ignored the mask, would raise `irq[2]` or raise an interrupt for a disabled slot. After each write, a read checks that the value survives and the interrupt clears, which catches a design that clears on the wrong slot or loses data on a read. Further directed steps check that dropping an enable bit kills a pending interrupt and that re-enabling does not bring it back. They also check that a write and a read in the same cycle leave the interrupt pending, and that unmapped offsets and upper enable bits read as zero.

// File: rtl/ipc_msg_pkg.sv
package ipc_msg_pkg;
    localparam int MSG_W = 32;

    typedef struct packed {
        logic [MSG_W-1:0] val;
        logic             pend;
    } slot_state_t;
endpackage

// File: rtl/ipc_msg_decode.sv
module ipc_msg_decode #(
    parameter int NUM_REGS  = 4,
    parameter int ADDR_W    = 9,
    parameter int STRIDE    = 16,
    parameter int EN_OFFSET = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [NUM_REGS-1:0] slot_wr,
    output logic [NUM_REGS-1:0] slot_rd,
    output logic                en_wr,
    output logic                en_rd
);
    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(EN_OFFSET);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot_dec
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(g * STRIDE);
        assign slot_wr[g] = wr_en && (addr == SLOT_ADDR);
        assign slot_rd[g] = rd_en && (addr == SLOT_ADDR);
    end

    assign en_wr = wr_en && (addr == EN_ADDR);
    assign en_rd = rd_en && (addr == EN_ADDR);

    // one address selects at most one slot, never a slot and the enable register together
    assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_wr, en_wr}));
endmodule

// File: rtl/ipc_msg_slot.sv
module ipc_msg_slot
    import ipc_msg_pkg::*;
#(
    parameter bit CAN_IRQ = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             rd_hit,
    input  logic             en_cur,
    input  logic             en_next,
    input  logic [MSG_W-1:0] wdata,
    output logic [MSG_W-1:0] val,
    output logic             pend
);
    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.val  = wdata;
            st_d.pend = en_cur && CAN_IRQ;
        end else if (rd_hit) begin
            st_d.pend = 1'b0;
        end
        if (!en_next) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val  = st_q.val;
    assign pend = st_q.pend;

    assert_arm_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && en_cur && en_next && CAN_IRQ) |=> (pend && val == $past(wdata)));
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !wr_hit) |=> !pend);
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !en_cur) |=> !pend);
    assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !CAN_IRQ |-> !pend);
    assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_cur |-> !pend);
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && rd_hit && en_cur && en_next && CAN_IRQ) |=> pend);
endmodule

// File: rtl/ipc_msg_bank.sv
module ipc_msg_bank
    import ipc_msg_pkg::*;
#(
    parameter int               NUM_REGS  = 4,
    parameter int               ADDR_W    = 9,
    parameter int               STRIDE    = 16,
    parameter int               EN_OFFSET = 256,
    parameter logic [NUM_REGS-1:0] RX_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [MSG_W-1:0]    wdata,
    output logic [MSG_W-1:0]    rdata,
    output logic [NUM_REGS-1:0] irq
);
    localparam int PAD_W = MSG_W - NUM_REGS;

    logic [NUM_REGS-1:0] slot_wr, slot_rd;
    logic                en_wr, en_rd;
    logic [NUM_REGS-1:0] en_d, en_q;
    logic [MSG_W-1:0]    slot_val [NUM_REGS];
    logic [NUM_REGS-1:0] slot_pend;

    ipc_msg_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .STRIDE   (STRIDE),
        .EN_OFFSET(EN_OFFSET)
    ) decode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .slot_wr(slot_wr),
        .slot_rd(slot_rd),
        .en_wr  (en_wr),
        .en_rd  (en_rd)
    );

    always_comb begin
        en_d = en_q;
        if (en_wr) en_d = wdata[NUM_REGS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        ipc_msg_slot #(.CAN_IRQ(RX_MASK[g])) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (slot_wr[g]),
            .rd_hit (slot_rd[g]),
            .en_cur (en_q[g]),
            .en_next(en_d[g]),
            .wdata  (wdata),
            .val    (slot_val[g]),
            .pend   (slot_pend[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (slot_rd[i]) rdata = rdata | slot_val[i];
        end
        if (en_rd) rdata = {{PAD_W{1'b0}}, en_q};
    end

    assign irq = slot_pend;

    assert_irq_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~en_q) == '0);
    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: tb/ipc_msg_bank_tb_top.sv
module ipc_msg_bank_tb_top;
    localparam logic [3:0] MASK = 4'b1011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_val [4];
    logic [3:0]  m_en;
    logic [3:0]  m_pend;

    always #5 clk = ~clk;

    ipc_msg_bank #(.RX_MASK(MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        if (a == 9'h100) return {28'd0, m_en};
        for (int i = 0; i < 4; i++) if (a == 9'(i * 16)) return m_val[i];
        return 32'd0;
    endfunction

    // one bus cycle: drive after negedge, check rdata, update model at edge, check irq
    task automatic op(input string tag, input logic [8:0] a, input logic w,
                      input logic r, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = w; rd_en = r; wdata = d;
        #1;
        check({tag, " rdata"}, rdata, r ? exp_read(a) : 32'd0);
        for (int i = 0; i < 4; i++) begin
            if (a == 9'(i * 16)) begin
                if (w) begin
                    m_val[i]  = d;
                    m_pend[i] = m_en[i] & MASK[i];
                end else if (r) begin
                    m_pend[i] = 1'b0;
                end
            end
        end
        if (w && a == 9'h100) begin
            m_en   = d[3:0];
            m_pend = m_pend & m_en;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
        check({tag, " irq"}, {28'd0, irq}, {28'd0, m_pend});
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_val[i] = '0;
        m_en = '0; m_pend = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq after reset", {28'd0, irq}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) op("R1 slot reset value", 9'(i * 16), 1'b0, 1'b1, 32'd0);
        op("R1 enable reset value", 9'h100, 1'b0, 1'b1, 32'd0);

        // sweep each slot over all enable patterns; R3 R5 R6 R7 then R4
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 16; p++) begin
                string t;
                t = !MASK[s] ? "R6" : (p[s] ? "R3" : "R5");
                op("R7 enable write", 9'h100, 1'b1, 1'b0, 32'(p));
                op(t, 9'(s * 16), 1'b1, 1'b0, 32'hA500_0000 | 32'(s << 8) | 32'(p));
                op("R4 read clears", 9'(s * 16), 1'b0, 1'b1, 32'd0);
                op("R4 value kept", 9'(s * 16), 1'b0, 1'b1, 32'd0);
            end
        end

        // R7: upper enable bits ignored
        op("R7 upper bits", 9'h100, 1'b1, 1'b0, 32'hFFFF_FFFF);
        op("R7 readback", 9'h100, 1'b0, 1'b1, 32'd0);

        // R8: disable drops pending, re-enable does not re-raise
        op("R8 arm slot0", 9'h000, 1'b1, 1'b0, 32'h1234_5678);
        op("R8 arm slot3", 9'h030, 1'b1, 1'b0, 32'h8765_4321);
        op("R8 disable slot0", 9'h100, 1'b1, 1'b0, 32'hE);
        op("R8 re-enable slot0", 9'h100, 1'b1, 1'b0, 32'hF);
        op("R8 slot0 value", 9'h000, 1'b0, 1'b1, 32'd0);

        // R9: write and read same slot same cycle
        op("R9 write+read", 9'h010, 1'b1, 1'b1, 32'hCAFE_0001);
        op("R9 new value", 9'h010, 1'b0, 1'b1, 32'd0);
        op("R9 masked write+read", 9'h020, 1'b1, 1'b1, 32'hCAFE_0002);

        // R2: unmapped offsets read zero, idle rdata zero
        op("R2 unmapped 0x004", 9'h004, 1'b0, 1'b1, 32'd0);
        op("R2 unmapped 0x040", 9'h040, 1'b0, 1'b1, 32'd0);
        op("R2 unmapped 0x104", 9'h104, 1'b0, 1'b1, 32'd0);
        op("R2 unmapped write", 9'h1F0, 1'b1, 1'b0, 32'hDEAD_BEEF);
        for (int i = 0; i < 4; i++) op("R2 slot intact", 9'(i * 16), 1'b0, 1'b1, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule